// File: doc/BRIEF.md
# Packet Timestamp Capture Queue

This block records the moment at which each timing event message starts to cross the port, in either direction. On a start-of-packet strobe it takes the current time (32-bit seconds, 32-bit nanoseconds). It stores that time with the message's 16-bit sequence number, its 4-bit message kind and a flag that marks a transmitted message. The records wait in a short first-in first-out queue until software collects them.

Software uses a 16-bit register bus. A status bit shows that records are waiting. To take one record, software sets a freeze bit, which copies the oldest record into a holding snapshot. It then reads four time words and two info words from that snapshot. Setting an end bit releases the record, and a write of zero returns the handshake to idle. Transmit and receive capture have separate enables. A queue that is full drops new captures and raises a sticky flag.

Register word addresses: 0 slice control (bit 0 transmit slice on, bit 8 receive slice on), 1 transmit capture control (bit 0 on), 2 status, 3 read control, 4 to 7 time words, 8 and 9 info words. Unused addresses read as zero.

Top module: `tsq_top`

## Requirements
- R1: After reset the status word (address 2) reads 0, `tsPending` is 0, and no record is held.
- R2: A transmit strobe is captured only when slice control bit 0 and transmit capture control bit 0 are both 1. Otherwise it is ignored and the queue is left unchanged.
- R3: A receive strobe is captured only when slice control bit 8 is 1. Otherwise it is ignored.
- R4: Status bit 1 and the output `tsPending` are 1 exactly while the queue holds one or more records. Status bit 0 and bits 15:3 read 0.
- R5: A write to read control (address 3) that takes bit 0 from 0 to 1 copies the oldest record into the snapshot, provided the queue is not empty. Addresses 4 to 9 read only the snapshot, so captures made afterwards do not change them.
- R6: Addresses 4, 5, 6 and 7 read, in that order, nanoseconds bits 15:0, nanoseconds bits 31:16, seconds bits 15:0 and seconds bits 31:16 of the captured time.
- R7: Address 8 reads the 16-bit sequence number as given, with no byte swap. Address 9 reads the message kind in bits 15:12 and a transmit flag in bit 11 (1 for transmit, 0 for receive). Bits 10:0 of address 9 read 0.
- R8: A read-control write that takes bit 1 from 0 to 1 removes the oldest record at that clock edge, so the pending status reflects the new count on the next cycle. Repeating the write with bit 1 still set removes nothing more. On an empty queue the write has no effect.
- R9: Records leave in capture order. When a transmit and a receive strobe are accepted in the same cycle, the transmit record comes first.
- R10: The queue holds 4 records. A capture that finds no free slot is dropped, and status bit 2 is set and stays set. In a single cycle with one free slot, the transmit capture is kept and the receive capture is dropped. Writing 1 to status bit 2 clears the flag, unless a drop happens in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curSec | input | 32 | Current time, seconds |
| curNs | input | 32 | Current time, nanoseconds |
| txSop | input | 1 | Transmit event start-of-packet strobe |
| txSeqId | input | 16 | Sequence number of the transmit message |
| txMsgType | input | 4 | Kind of the transmit message |
| rxSop | input | 1 | Receive event start-of-packet strobe |
| rxSeqId | input | 16 | Sequence number of the receive message |
| rxMsgType | input | 4 | Kind of the receive message |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| tsPending | output | 1 | High while one or more records are queued |

## Verification
The hardest situations to reach are the cycles where several events land together. Examples are a transmit and a receive strobe arriving when only one slot is free, and captures arriving after the snapshot is frozen but before the record is released. Directed sequences fill the queue to three records and then fire both strobes at once. They also freeze the head record and inject a new capture before reading the words back. A seeded random mix of single and paired captures, drains and overflow clears then runs against a queue model in the bench. Drains interleave with pushes, so the pointers wrap many times.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  localparam int ADDR_SLICE  = 0;
  localparam int ADDR_TXCAP  = 1;
  localparam int ADDR_STATUS = 2;
  localparam int ADDR_RDCTL  = 3;
  localparam int ADDR_TS0    = 4;
  localparam int ADDR_TS1    = 5;
  localparam int ADDR_TS2    = 6;
  localparam int ADDR_TS3    = 7;
  localparam int ADDR_INFO0  = 8;
  localparam int ADDR_INFO1  = 9;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] ns;
    logic [15:0] seqId;
    logic [3:0]  msgType;
    logic        isTx;
  } tsRecord_t;

  typedef struct packed {
    logic pushTx;
    logic pushRx;
    logic pop;
    logic freeze;
  } qStrobe_t;

endpackage

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  input  logic              txSop,
  input  logic              rxSop,
  output qStrobe_t          stb,
  output logic [15:0]       sliceWord,
  output logic [15:0]       capWord,
  output logic [15:0]       statusWord,
  output logic [15:0]       rdCtlWord,
  output logic              pending
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             txSliceEn, rxSliceEn, txCapEn, ovfFlag;
  logic [1:0]       rdCtl;
  logic [CNT_W-1:0] count, freeSlots;
  logic             wrSlice, wrCap, wrStatus, wrRdCtl;
  logic             txReq, rxReq, dropAny;

  assign wrSlice  = regWrEn && (regAddr == ADDR_W'(ADDR_SLICE));
  assign wrCap    = regWrEn && (regAddr == ADDR_W'(ADDR_TXCAP));
  assign wrStatus = regWrEn && (regAddr == ADDR_W'(ADDR_STATUS));
  assign wrRdCtl  = regWrEn && (regAddr == ADDR_W'(ADDR_RDCTL));

  assign freeSlots = CNT_W'(DEPTH) - count;
  assign txReq = txSop && txSliceEn && txCapEn;
  assign rxReq = rxSop && rxSliceEn;

  always_comb begin
    stb.pushTx = txReq && (freeSlots != '0);
    stb.pushRx = rxReq && (freeSlots > (stb.pushTx ? CNT_W'(1) : CNT_W'(0)));
    stb.pop    = wrRdCtl && regWrData[1] && !rdCtl[1] && (count != '0);
    stb.freeze = wrRdCtl && regWrData[0] && !rdCtl[0] && (count != '0);
    dropAny    = (txReq && !stb.pushTx) || (rxReq && !stb.pushRx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSliceEn <= 1'b0;
      rxSliceEn <= 1'b0;
      txCapEn   <= 1'b0;
      rdCtl     <= '0;
    end else begin
      if (wrSlice) begin
        txSliceEn <= regWrData[0];
        rxSliceEn <= regWrData[8];
      end
      if (wrCap)   txCapEn <= regWrData[0];
      if (wrRdCtl) rdCtl   <= regWrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      count <= count + CNT_W'(stb.pushTx) + CNT_W'(stb.pushRx) - CNT_W'(stb.pop);
      if (dropAny)                        ovfFlag <= 1'b1;
      else if (wrStatus && regWrData[2])  ovfFlag <= 1'b0;
    end
  end

  assign pending    = (count != '0);
  assign sliceWord  = {7'b0, rxSliceEn, 7'b0, txSliceEn};
  assign capWord    = {15'b0, txCapEn};
  assign statusWord = {13'b0, ovfFlag, pending, 1'b0};
  assign rdCtlWord  = {14'b0, rdCtl};

  // R10: occupancy never passes the depth
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10: the overflow flag stays set until a clear write
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrStatus && regWrData[2])) |=> ovfFlag);

  // R2: transmit pushes need both transmit enables
  p_tx_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushTx |-> (txSliceEn && txCapEn));

  // R8: a lone pop lowers the count by one
  p_pop_decr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.pushTx && !stb.pushRx) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/tsq_datapath.sv
module tsq_datapath
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          stb,
  input  logic [31:0]       curSec,
  input  logic [31:0]       curNs,
  input  logic [15:0]       txSeqId,
  input  logic [3:0]        txMsgType,
  input  logic [15:0]       rxSeqId,
  input  logic [3:0]        rxMsgType,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       sliceWord,
  input  logic [15:0]       capWord,
  input  logic [15:0]       statusWord,
  input  logic [15:0]       rdCtlWord,
  output logic [15:0]       regRdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tsRecord_t        slots [DEPTH];
  tsRecord_t        txRec, rxRec, snapRec;
  logic [PTR_W-1:0] wrPtr, rdPtr, rxSlot;

  assign txRec  = '{sec: curSec, ns: curNs, seqId: txSeqId, msgType: txMsgType, isTx: 1'b1};
  assign rxRec  = '{sec: curSec, ns: curNs, seqId: rxSeqId, msgType: rxMsgType, isTx: 1'b0};
  assign rxSlot = stb.pushTx ? wrPtr + PTR_W'(1) : wrPtr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slots[i] <= '0;
      end else if (stb.pushTx && (wrPtr == PTR_W'(i))) begin
        slots[i] <= txRec;
      end else if (stb.pushRx && (rxSlot == PTR_W'(i))) begin
        slots[i] <= rxRec;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      snapRec <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(stb.pushTx) + PTR_W'(stb.pushRx);
      rdPtr <= rdPtr + PTR_W'(stb.pop);
      if (stb.freeze) snapRec <= slots[rdPtr];
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(ADDR_SLICE):  regRdData = sliceWord;
      ADDR_W'(ADDR_TXCAP):  regRdData = capWord;
      ADDR_W'(ADDR_STATUS): regRdData = statusWord;
      ADDR_W'(ADDR_RDCTL):  regRdData = rdCtlWord;
      ADDR_W'(ADDR_TS0):    regRdData = snapRec.ns[15:0];
      ADDR_W'(ADDR_TS1):    regRdData = snapRec.ns[31:16];
      ADDR_W'(ADDR_TS2):    regRdData = snapRec.sec[15:0];
      ADDR_W'(ADDR_TS3):    regRdData = snapRec.sec[31:16];
      ADDR_W'(ADDR_INFO0):  regRdData = snapRec.seqId;
      ADDR_W'(ADDR_INFO1):  regRdData = {snapRec.msgType, snapRec.isTx, 11'b0};
      default:              regRdData = '0;
    endcase
  end

  // R5: the snapshot only moves on a freeze
  p_snap_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.freeze |=> $stable(snapRec));

  // R9: the read pointer only moves on a pop
  p_rdptr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pop |=> $stable(rdPtr));

endmodule

// File: rtl/tsq_top.sv
module tsq_top
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       curSec,
  input  logic [31:0]       curNs,
  input  logic              txSop,
  input  logic [15:0]       txSeqId,
  input  logic [3:0]        txMsgType,
  input  logic              rxSop,
  input  logic [15:0]       rxSeqId,
  input  logic [3:0]        rxMsgType,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              tsPending
);
  qStrobe_t    stb;
  logic [15:0] sliceWord, capWord, statusWord, rdCtlWord;

  tsq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .txSop(txSop), .rxSop(rxSop), .stb(stb),
    .sliceWord(sliceWord), .capWord(capWord), .statusWord(statusWord),
    .rdCtlWord(rdCtlWord), .pending(tsPending)
  );

  tsq_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curSec(curSec), .curNs(curNs),
    .txSeqId(txSeqId), .txMsgType(txMsgType), .rxSeqId(rxSeqId),
    .rxMsgType(rxMsgType), .regAddr(regAddr), .sliceWord(sliceWord),
    .capWord(capWord), .statusWord(statusWord), .rdCtlWord(rdCtlWord),
    .regRdData(regRdData)
  );

  // R4: pending drops only through a pop
  p_pending_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tsPending && !stb.pop) |=> tsPending);

endmodule

// File: tb/tb_tsq_top.sv
`timescale 1ns/1ps
module tb_tsq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] curSec = '0, curNs = '0;
  logic        txSop = 1'b0, rxSop = 1'b0;
  logic [15:0] txSeqId = '0, rxSeqId = '0;
  logic [3:0]  txMsgType = '0, rxMsgType = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        tsPending;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // model state
  logic [84:0] mq[$];
  bit mOvf = 1'b0, mTxSlice = 1'b0, mRxSlice = 1'b0, mTxCap = 1'b0;
  logic [1:0]  mRdCtl = '0;
  logic [84:0] mSnap = '0;

  always #2 clk = ~clk;

  tsq_top dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [84:0] mkRec(logic [31:0] s, logic [31:0] n, logic [15:0] q, logic [3:0] t, logic d);
    return {s, n, q, t, d};
  endfunction

  function automatic logic [15:0] recWord(logic [84:0] r, int addr);
    case (addr)
      4: return r[52:37];
      5: return r[68:53];
      6: return r[84:69];
      7: return r[84:69] ^ r[84:69] | r[84:69] >> 0 == 0 ? 16'h0 : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] expWord(logic [84:0] r, int addr);
    logic [31:0] s = r[84:53];
    logic [31:0] n = r[52:21];
    case (addr)
      4: return n[15:0];
      5: return n[31:16];
      6: return s[15:0];
      7: return s[31:16];
      8: return r[20:5];
      9: return {r[4:1], r[0], 11'b0};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] expStatus();
    return {13'b0, mOvf, (mq.size() != 0), 1'b0};
  endfunction

  task automatic regWrite(input int addr, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (addr == 0) begin mTxSlice = data[0]; mRxSlice = data[8]; end
    if (addr == 1) mTxCap = data[0];
    if (addr == 2 && data[2]) mOvf = 1'b0;
    if (addr == 3) begin
      if (data[0] && !mRdCtl[0] && mq.size() != 0) mSnap = mq[0];
      if (data[1] && !mRdCtl[1] && mq.size() != 0) void'(mq.pop_front());
      mRdCtl = data[1:0];
    end
  endtask

  task automatic regRead(input int addr, output logic [15:0] val);
    regAddr = 4'(addr);
    #1 val = regRdData;
  endtask

  task automatic capture(input bit doTx, input bit doRx, input logic [31:0] s, input logic [31:0] n,
                         input logic [15:0] tq, input logic [3:0] tt, input logic [15:0] rq, input logic [3:0] rt);
    @(negedge clk);
    curSec = s; curNs = n;
    txSop = doTx; txSeqId = tq; txMsgType = tt;
    rxSop = doRx; rxSeqId = rq; rxMsgType = rt;
    @(negedge clk);
    txSop = 1'b0; rxSop = 1'b0;
    if (doTx && mTxSlice && mTxCap) begin
      if (mq.size() < 4) mq.push_back(mkRec(s, n, tq, tt, 1'b1)); else mOvf = 1'b1;
    end
    if (doRx && mRxSlice) begin
      if (mq.size() < 4) mq.push_back(mkRec(s, n, rq, rt, 1'b0)); else mOvf = 1'b1;
    end
  endtask

  task automatic checkStatus(input string tag);
    logic [15:0] v;
    regRead(2, v);
    chk(v == expStatus(), tag, 64'(v), 64'(expStatus()));
    chk(tsPending == (mq.size() != 0), {tag, " R4 pin"}, 64'(tsPending), 64'(mq.size() != 0));
  endtask

  task automatic checkSnapWords(input logic [84:0] r, input string tag);
    logic [15:0] v;
    for (int a = 4; a <= 9; a++) begin
      regRead(a, v);
      chk(v == expWord(r, a), $sformatf("%s word%0d", tag, a), 64'(v), 64'(expWord(r, a)));
    end
  endtask

  task automatic drainOne(input string tag);
    logic [84:0] head;
    head = mq[0];
    regWrite(3, 16'h1);
    checkSnapWords(head, tag);
    regWrite(3, 16'h3);
    regWrite(3, 16'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [84:0] keep;
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkStatus("R1 reset status");

    // R2: transmit gated when capture enable is off
    regWrite(0, 16'h0101);
    capture(1, 0, 32'h11, 32'h22, 16'h1234, 4'h0, 16'h0, 4'h0);
    checkStatus("R2 tx ignored without capture enable");
    regWrite(1, 16'h1);
    regWrite(0, 16'h0100);
    capture(1, 0, 32'h11, 32'h22, 16'h1234, 4'h0, 16'h0, 4'h0);
    checkStatus("R2 tx ignored without slice enable");

    // R3: receive gated by slice bit 8
    regWrite(0, 16'h0001);
    capture(0, 1, 32'h33, 32'h44, 16'h0, 4'h0, 16'h5678, 4'h3);
    checkStatus("R3 rx ignored");
    regWrite(0, 16'h0101);

    // R6 R7 R9: simultaneous capture, transmit first
    capture(1, 1, 32'hA1B2C3D4, 32'h1F2E3D4C, 16'hBEEF, 4'h2, 16'h00C3, 4'h9);
    checkStatus("R4 pending after pair");
    drainOne("R6 R7 R9 tx first");
    drainOne("R6 R7 R9 rx second");
    checkStatus("R8 empty after drains");

    // R5: snapshot holds while new captures arrive
    capture(1, 0, 32'h1, 32'h2, 16'h0042, 4'h1, 16'h0, 4'h0);
    keep = mq[0];
    regWrite(3, 16'h1);
    capture(0, 1, 32'hFFFF0000, 32'h0000FFFF, 16'h0, 4'h0, 16'h9999, 4'hF);
    checkSnapWords(keep, "R5 frozen");
    regWrite(3, 16'h3);
    // R8: second end write without going idle pops nothing
    regWrite(3, 16'h3);
    checkStatus("R8 single pop");
    regWrite(3, 16'h0);
    drainOne("R8 remaining record");
    // R8: end on empty has no effect
    regWrite(3, 16'h2);
    regWrite(3, 16'h0);
    checkStatus("R8 empty pop");
    capture(1, 0, 32'h7, 32'h8, 16'h0007, 4'h4, 16'h0, 4'h0);
    drainOne("R8 after empty pop");

    // R10: fill to three, then a pair: tx kept, rx dropped
    for (int i = 0; i < 3; i++)
      capture(0, 1, 32'(i), 32'(i * 10), 16'(100 + i), 4'(i), 16'(200 + i), 4'(i + 1));
    capture(1, 1, 32'h55, 32'h66, 16'hAAAA, 4'h5, 16'hBBBB, 4'h6);
    checkStatus("R10 overflow pair");
    capture(1, 0, 32'h57, 32'h68, 16'hCCCC, 4'h7, 16'h0, 4'h0);
    checkStatus("R10 overflow full");
    for (int i = 0; i < 4; i++) drainOne("R10 R9 order after overflow");
    checkStatus("R10 flag sticky after drain");
    regWrite(2, 16'h4);
    checkStatus("R10 flag cleared");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 7);
      logic [31:0] s = $urandom, n = $urandom;
      logic [15:0] q1 = 16'($urandom), q2 = 16'($urandom);
      logic [3:0]  t1 = 4'($urandom), t2 = 4'($urandom);
      if (op == 0) capture(1, 0, s, n, q1, t1, q2, t2);
      else if (op == 1) capture(0, 1, s, n, q1, t1, q2, t2);
      else if (op == 2) capture(1, 1, s, n, q1, t1, q2, t2);
      else if (op == 6) regWrite(2, 16'h4);
      else if (mq.size() != 0) drainOne("R9 random order");
      if (it % 8 == 0) checkStatus("R4 R10 random status");
    end
    while (mq.size() != 0) drainOne("R9 final drain");
    checkStatus("R4 final empty");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule